// File: doc/BRIEF.md
# Input Frame Offset Alignment Unit

On a large switching backplane the frame pulse and the serial data lanes reach a switch device by different routes, so the first bit of an incoming frame can arrive several interface clocks after the pulse. This unit takes that skew out of the receive path, one stream at a time. Software stores a small offset for each input stream. The unit then delays that stream's sampling reference by the stored number of clocks and starts a virtual input frame there. It also runs the bit and channel counters that turn the serial lane into channel bytes.

The transmit side stays locked to the raw frame pulse. A separate pair of output counters marks bit and channel positions for the output framing, and no offset setting changes them. The offset feature only applies at the two faster interface rates. At the base rate, or when the global enable is low, every stream behaves as if its offset were zero. A new offset value is held aside until the next frame pulse, so a frame that is already running is never cut short in the middle by a register write.

Top module: `ifo_align`

## Requirements
- R1: After reset, byte_vld_o and vfp_o are all low, and out_bit_o and out_ch_o read zero.
- R2: On the clock edge that samples fp_i high, out_bit_o and out_ch_o become 0. On each later edge, out_bit_o advances 0 to 7, and out_ch_o advances after bit 7 and wraps after the frame's last channel. Per-stream offsets never affect these counters.
- R3: rate_i selects the channels per frame: 2'b00 gives 32 (base rate), 2'b01 gives 64 (double rate) and 2'b10 gives 128 (quadruple rate). 2'b11 acts exactly like 2'b00.
- R4: When wr_en_i is high, wr_data_i is stored as the offset of stream wr_sel_i. Values 5, 6 and 7 are stored as 4.
- R5: A stored offset is applied only at the next edge that samples fp_i high. A write in mid-frame leaves the running frame's alignment unchanged.
- R6: The offset applied at a frame pulse is zero for every stream when off_en_i is low, or when rate_i selects the base rate (2'b00 or 2'b11). Both inputs are sampled together with fp_i.
- R7: With applied offset k for stream s, vfp_o[s] goes high for one cycle, on the edge k cycles after the edge that samples fp_i.
- R8: Stream s is sampled MSB first. Channel c's byte is made from the bits sampled on edges k+8c through k+8c+7 after the pulse edge. On the edge that samples the last bit, byte_o[8s+:8] carries that byte, byte_ch_o[7s+:7] carries c, and byte_vld_o[s] rises for one cycle.
- R9: An applied offset of 0 gives timing identical to the feature being disabled: bit 0 of channel 0 is sampled on the pulse edge itself.
- R10: No byte is emitted before a stream's first virtual frame start. A byte cut short by a new virtual frame start, or partial bits in the gap before a later start, is never emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial interface clock, one bit per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fp_i | input | 1 | Frame pulse, high for the cycle carrying raw bit 0 |
| rate_i | input | 2 | Interface rate select |
| off_en_i | input | 1 | Global enable of input offsets |
| wr_en_i | input | 1 | Offset write strobe |
| wr_sel_i | input | 2 | Stream index for the write |
| wr_data_i | input | 3 | Offset value to write |
| sd_i | input | 4 | Serial data, one bit per stream |
| out_bit_o | output | 3 | Output-frame bit position |
| out_ch_o | output | 7 | Output-frame channel position |
| vfp_o | output | 4 | Per-stream virtual frame start pulse |
| byte_vld_o | output | 4 | Per-stream recovered byte strobe |
| byte_o | output | 32 | Recovered bytes, stream s at bits 8s+7..8s |
| byte_ch_o | output | 28 | Channel of each byte, stream s at bits 7s+6..7s |

## Verification
An applied offset that is wrong, or that changes at the wrong moment, moves vfp_o[s] off its expected edge within at most four cycles of the pulse. The first recovered byte of that frame then reaches the ports with the wrong value, eight cycles later. A bit or channel counter that slips shows up as a wrong byte_ch_o or a byte strobe with no matching item in the scoreboard. A fault in the output counters shows on the very next cycle, because both counters are compared on every clock. The cases that matter most are the frame pulses at which an offset grows or shrinks, where the truncated or gap bits must not come out as a byte.

// File: rtl/ifo_pkg.sv
package ifo_pkg;
  typedef enum logic [1:0] {
    RATE_BASE = 2'b00,
    RATE_X2   = 2'b01,
    RATE_X4   = 2'b10,
    RATE_ALT  = 2'b11
  } rate_e;

  localparam int BYTE_W = 8;
  localparam int BIT_W  = 3;
endpackage

// File: rtl/ifo_off_regs.sv
module ifo_off_regs #(
  parameter int N_STR   = 4,
  parameter int MAX_OFF = 4,
  parameter int OFF_W   = 3,
  parameter int SEL_W   = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        fp_i,
  input  logic [1:0]                  rate_i,
  input  logic                        off_en_i,
  input  logic                        wr_en_i,
  input  logic [SEL_W-1:0]            wr_sel_i,
  input  logic [2:0]                  wr_data_i,
  output logic [N_STR-1:0][OFF_W-1:0] off_now_o
);
  import ifo_pkg::*;

  logic [N_STR-1:0][OFF_W-1:0] shadow_q, pend, active_q;
  logic                        allow;
  logic [OFF_W-1:0]            wr_sat;

  assign allow  = off_en_i && (rate_i == RATE_X2 || rate_i == RATE_X4);
  assign wr_sat = (int'(wr_data_i) > MAX_OFF) ? OFF_W'(MAX_OFF) : OFF_W'(wr_data_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shadow_q <= '0;
    else if (wr_en_i) shadow_q[wr_sel_i] <= wr_sat;
  end

  always_comb begin
    for (int s = 0; s < N_STR; s++) pend[s] = allow ? shadow_q[s] : '0;
  end

  // applied set only moves on a frame pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) active_q <= '0;
    else if (fp_i) active_q <= pend;
  end

  // on the pulse cycle itself the incoming set is already in force
  assign off_now_o = fp_i ? pend : active_q;

  generate
    for (genvar g = 0; g < N_STR; g++) begin : g_chk
      a_r4_active_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(active_q[g]) <= MAX_OFF);
    end
  endgenerate

  a_r5_hold_mid_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fp_i |=> $stable(active_q));

  a_r6_forced_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fp_i && (!off_en_i || rate_i == RATE_BASE || rate_i == RATE_ALT)) |=> (active_q == '0));
endmodule

// File: rtl/ifo_out_timer.sv
module ifo_out_timer #(
  parameter int CH_W = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fp_i,
  input  logic [CH_W-1:0] ch_lim_i,
  output logic [2:0]      bit_o,
  output logic [CH_W-1:0] ch_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_o <= '0;
      ch_o  <= '0;
    end else if (fp_i) begin
      bit_o <= '0;
      ch_o  <= '0;
    end else if (bit_o == 3'd7) begin
      bit_o <= '0;
      ch_o  <= (ch_o == ch_lim_i) ? '0 : ch_o + 1'b1;
    end else begin
      bit_o <= bit_o + 1'b1;
    end
  end

  a_r2_fp_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_i |=> (bit_o == '0 && ch_o == '0));

  a_r2_bit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fp_i && bit_o != 3'd7) |=> (bit_o == $past(bit_o) + 3'd1 && ch_o == $past(ch_o)));
endmodule

// File: rtl/ifo_lane.sv
module ifo_lane #(
  parameter int MAX_OFF = 4,
  parameter int OFF_W   = 3,
  parameter int CH_W    = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fp_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [CH_W-1:0]  ch_lim_i,
  input  logic             sd_i,
  output logic             vfp_o,
  output logic             byte_vld_o,
  output logic [7:0]       byte_o,
  output logic [CH_W-1:0]  byte_ch_o
);
  logic [MAX_OFF-1:0] fp_hist_q;
  logic               vfp, running_q, live;
  logic [2:0]         bit_q, cur_bit;
  logic [CH_W-1:0]    ch_q, cur_ch;
  logic [6:0]         sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fp_hist_q <= '0;
    else         fp_hist_q <= {fp_hist_q[MAX_OFF-2:0], fp_i};
  end

  // tap select: offset 0 uses the live pulse
  always_comb begin
    vfp = (off_i == '0) && fp_i;
    for (int i = 0; i < MAX_OFF; i++)
      if (off_i == OFF_W'(i + 1)) vfp = fp_hist_q[i];
  end

  assign cur_bit = vfp ? '0 : bit_q;
  assign cur_ch  = vfp ? '0 : ch_q;
  assign live    = vfp || running_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q  <= 1'b0;
      bit_q      <= '0;
      ch_q       <= '0;
      sh_q       <= '0;
      vfp_o      <= 1'b0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
      byte_ch_o  <= '0;
    end else begin
      vfp_o      <= vfp;
      byte_vld_o <= 1'b0;
      if (live) begin
        running_q <= 1'b1;
        sh_q      <= {sh_q[5:0], sd_i};
        if (cur_bit == 3'd7) begin
          bit_q      <= '0;
          ch_q       <= (cur_ch == ch_lim_i) ? '0 : cur_ch + 1'b1;
          byte_vld_o <= 1'b1;
          byte_o     <= {sh_q, sd_i};
          byte_ch_o  <= cur_ch;
        end else begin
          bit_q <= cur_bit + 1'b1;
          ch_q  <= cur_ch;
        end
      end
    end
  end

  a_r8_vld_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |=> !byte_vld_o);

  a_r10_idle_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running_q && !vfp) |=> !byte_vld_o);

  a_r7_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vfp |=> (bit_q == 3'd1 && ch_q == '0 && vfp_o));
endmodule

// File: rtl/ifo_align.sv
module ifo_align #(
  parameter int N_STR   = 4,
  parameter int BASE_CH = 32,
  parameter int MAX_OFF = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       fp_i,
  input  logic [1:0]                 rate_i,
  input  logic                       off_en_i,
  input  logic                       wr_en_i,
  input  logic [$clog2(N_STR)-1:0]   wr_sel_i,
  input  logic [2:0]                 wr_data_i,
  input  logic [N_STR-1:0]           sd_i,
  output logic [2:0]                 out_bit_o,
  output logic [$clog2(BASE_CH*4)-1:0] out_ch_o,
  output logic [N_STR-1:0]           vfp_o,
  output logic [N_STR-1:0]           byte_vld_o,
  output logic [N_STR*8-1:0]         byte_o,
  output logic [N_STR*$clog2(BASE_CH*4)-1:0] byte_ch_o
);
  import ifo_pkg::*;

  localparam int CH_W  = $clog2(BASE_CH * 4);
  localparam int OFF_W = $clog2(MAX_OFF + 1);
  localparam int SEL_W = $clog2(N_STR);

  logic [N_STR-1:0][OFF_W-1:0] off_now;
  logic [CH_W-1:0]             ch_lim;

  always_comb begin
    unique case (rate_i)
      RATE_X2: ch_lim = CH_W'(BASE_CH * 2 - 1);
      RATE_X4: ch_lim = CH_W'(BASE_CH * 4 - 1);
      default: ch_lim = CH_W'(BASE_CH - 1);
    endcase
  end

  ifo_off_regs #(
    .N_STR(N_STR), .MAX_OFF(MAX_OFF), .OFF_W(OFF_W), .SEL_W(SEL_W)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .fp_i(fp_i), .rate_i(rate_i),
    .off_en_i(off_en_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .off_now_o(off_now)
  );

  ifo_out_timer #(.CH_W(CH_W)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .fp_i(fp_i), .ch_lim_i(ch_lim),
    .bit_o(out_bit_o), .ch_o(out_ch_o)
  );

  generate
    for (genvar g = 0; g < N_STR; g++) begin : g_lane
      ifo_lane #(.MAX_OFF(MAX_OFF), .OFF_W(OFF_W), .CH_W(CH_W)) u_lane (
        .clk_i(clk_i), .rst_ni(rst_ni), .fp_i(fp_i), .off_i(off_now[g]),
        .ch_lim_i(ch_lim), .sd_i(sd_i[g]), .vfp_o(vfp_o[g]),
        .byte_vld_o(byte_vld_o[g]), .byte_o(byte_o[g*8 +: 8]),
        .byte_ch_o(byte_ch_o[g*CH_W +: CH_W])
      );
    end
  endgenerate
endmodule

// File: tb/ifo_align_bench.sv
module ifo_align_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int CW = 7;

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic           fp_i = 1'b0;
  logic [1:0]     rate_i = 2'b01;
  logic           off_en_i = 1'b0;
  logic           wr_en_i = 1'b0;
  logic [1:0]     wr_sel_i = '0;
  logic [2:0]     wr_data_i = '0;
  logic [N-1:0]   sd_i = '0;
  logic [2:0]     out_bit_o;
  logic [CW-1:0]  out_ch_o;
  logic [N-1:0]   vfp_o, byte_vld_o;
  logic [N*8-1:0] byte_o;
  logic [N*CW-1:0] byte_ch_o;

  ifo_align u_ifo_align (
    .clk_i(clk), .rst_ni(rst_ni), .fp_i(fp_i), .rate_i(rate_i),
    .off_en_i(off_en_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .sd_i(sd_i), .out_bit_o(out_bit_o),
    .out_ch_o(out_ch_o), .vfp_o(vfp_o), .byte_vld_o(byte_vld_o),
    .byte_o(byte_o), .byte_ch_o(byte_ch_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  logic [14:0]   exp_q [N][$];  // {ch, byte}
  logic [N+10:0] slot_q[$];     // {chk, vfp[N], ch, bit}

  int  cur_k[N], prev_k[N], shadow_m[N];
  int  cur_bits, prev_bits, fidx, t;
  bit  started, prev_valid, en_m;
  logic [1:0] rate_m;
  int  pend_val[N];
  logic [N-1:0] pend_mask;

  function automatic logic [7:0] pat(int s, int f, int c);
    return 8'((s * 53 + f * 29 + c * 7 + 90) ^ (c * 8));
  endfunction

  function automatic int chans(logic [1:0] r);
    if (r == 2'b01) return 64;
    if (r == 2'b10) return 128;
    return 32;  // R3: 00 and 11 both base rate
  endfunction

  function automatic int eff_k(int s);
    if (en_m && (rate_m == 2'b01 || rate_m == 2'b10)) return shadow_m[s];
    return 0;   // R6, R9
  endfunction

  task automatic drive_slot(bit is_fp, bit do_wr, int wsel, int wval);
    logic [N-1:0] vexp, sd;
    @(negedge clk);
    rate_i   = rate_m;
    off_en_i = en_m;
    if (is_fp) begin
      prev_valid = started;
      prev_bits  = cur_bits;
      for (int s = 0; s < N; s++) begin
        prev_k[s] = cur_k[s];
        cur_k[s]  = eff_k(s);
      end
      cur_bits = chans(rate_m) * 8;
      fidx++;
      started = 1;
      t = 0;
    end
    fp_i      = is_fp;
    wr_en_i   = do_wr;
    wr_sel_i  = 2'(wsel);
    wr_data_i = 3'(wval);
    for (int s = 0; s < N; s++) begin
      int p, q;
      logic [7:0] d;
      sd[s] = 1'b0;
      p = t - cur_k[s];
      if (started && p >= 0) begin
        if (p < cur_bits) begin
          d = pat(s, fidx, p / 8);
          sd[s] = d[7 - p % 8];
          if (p % 8 == 7) exp_q[s].push_back({7'(p / 8), d});
        end
      end else if (started && prev_valid) begin
        q = prev_bits + t - prev_k[s];
        if (q < prev_bits) begin   // R10: truncated tail never completes
          d = pat(s, fidx - 1, q / 8);
          sd[s] = d[7 - q % 8];
          if (q % 8 == 7) exp_q[s].push_back({7'(q / 8), d});
        end
      end
      vexp[s] = started && (t == cur_k[s]);
    end
    sd_i = sd;
    slot_q.push_back({started, vexp, 7'((t / 8) % (cur_bits / 8 > 0 ? cur_bits / 8 : 1)), 3'(t % 8)});
    if (do_wr) shadow_m[wsel] = (wval > 4) ? 4 : wval;  // R4 saturation
    t++;
  endtask

  task automatic run_frame(logic [1:0] r, bit en);
    int len;
    rate_m = r;
    en_m   = en;
    len    = chans(r) * 8;
    for (int i = 0; i < len; i++) begin
      if (i == 0) drive_slot(1, 0, 0, 0);
      else if (i >= 20 && i < 20 + N && pend_mask[i - 20])
        drive_slot(0, 1, i - 20, pend_val[i - 20]);
      else drive_slot(0, 0, 0, 0);
    end
    pend_mask = '0;
  endtask

  task automatic chk(bit ok, string req, int act, int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, expv, $time);
    end
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    #2;
    if (rst_ni && !done && slot_q.size() > 0) begin
      logic [N+10:0] e;
      e = slot_q.pop_front();
      if (e[N+10]) begin
        chk(out_bit_o == e[2:0], "R2 out_bit", out_bit_o, e[2:0]);
        chk(out_ch_o == e[9:3], "R2 out_ch", out_ch_o, e[9:3]);
        chk(vfp_o == e[N+9:10], "R7 vfp", vfp_o, e[N+9:10]);
      end
      for (int s = 0; s < N; s++) begin
        if (byte_vld_o[s]) begin
          if (exp_q[s].size() == 0) chk(0, "R10 unexpected byte", s, -1);
          else begin
            logic [14:0] x;
            x = exp_q[s].pop_front();
            chk(byte_o[s*8 +: 8] == x[7:0], "R8 byte", byte_o[s*8 +: 8], x[7:0]);
            chk(byte_ch_o[s*CW +: CW] == x[14:8], "R8 ch", byte_ch_o[s*CW +: CW], x[14:8]);
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    started = 0; prev_valid = 0; fidx = 0; t = 0;
    cur_bits = 256; prev_bits = 256; en_m = 1; rate_m = 2'b01;
    pend_mask = '0;
    for (int s = 0; s < N; s++) begin
      cur_k[s] = 0; prev_k[s] = 0; shadow_m[s] = 0; pend_val[s] = 0;
    end
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk(byte_vld_o == '0, "R1 vld", byte_vld_o, 0);
    chk(vfp_o == '0, "R1 vfp", vfp_o, 0);
    chk(out_bit_o == '0 && out_ch_o == '0, "R1 counters", out_ch_o, 0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R5: writes in this frame must not move it
    pend_val = '{0, 1, 2, 3}; pend_mask = 4'hF;
    run_frame(2'b01, 1);
    run_frame(2'b01, 1);
    run_frame(2'b01, 1);
    // R4 (7 saturates), R10 offset grow on s0, shrink on s2
    pend_val = '{4, 7, 1, 0}; pend_mask = 4'hF;
    run_frame(2'b01, 1);
    run_frame(2'b01, 1);
    run_frame(2'b01, 1);
    // R6: disabled at quadruple rate, registers written meanwhile
    pend_val = '{2, 3, 4, 1}; pend_mask = 4'hF;
    run_frame(2'b10, 0);
    pend_val = '{0, 0, 0, 0}; pend_mask = 4'h8;
    run_frame(2'b10, 0);
    // R9: enabled, stream 3 offset 0 matches disabled timing
    run_frame(2'b10, 1);
    run_frame(2'b10, 1);
    // R6 base rate forces zero; R3 code 11 acts as base
    run_frame(2'b00, 1);
    run_frame(2'b00, 1);
    run_frame(2'b11, 1);
    for (int i = 0; i < 6; i++) drive_slot(0, 0, 0, 0);
    repeat (4) @(posedge clk);
    #3;
    for (int s = 0; s < N; s++)
      chk(exp_q[s].size() == 0, "R8 missing bytes", exp_q[s].size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule